// File: doc/BRIEF.md
# I2C Slave Bus Status Monitor

This block sits beside an I2C slave protocol engine and watches both the engine and the physical bus. It keeps four sticky status flags. The first catches a mismatch between the level the slave drives onto SDA and the level actually seen on the line, which points to bus contention or a weak pull-up. The second records that an address was detected while the engine ran in its low-clock asynchronous detection mode. The third records a NAK from the master after a byte the slave sent. The fourth records a stop condition seen while the slave was selected.

Software clears each flag by writing 1 to its bit; writing 0 leaves it alone. A single enable gates a level interrupt built from all four flags. When a stop arrives while the slave is selected, the block also sends a one-cycle release request to the engine. The engine then lets go of SDA and SCL and returns to idle to wait for the next start. Byte shifting and address matching stay inside the engine.

Top module: `i2c_bus_status_mon`

## Requirements
- R1: On a cycle with `sda_stb`=1, `tx_active`=1 and `async_mode`=0, where `sda_in` differs from `drv_sda`, the mismatch flag (`flags[3]`) is 1 after the next clock edge.
- R2: When `sda_in` equals `drv_sda`, or `sda_stb`=0, or `tx_active`=0, the mismatch flag is not set.
- R3: `ack_valid`=1 with `ack_bit`=1 (NAK) sets the NAK flag (`flags[1]`); `ack_bit`=0 (ACK) leaves it clear.
- R4: `stop_pulse`=1 sets the stop flag (`flags[0]`) only when `selected`=1 in the same cycle.
- R5: `bus_release` is a registered one-cycle pulse that is high in the same cycle the stop flag is set by a stop seen while selected. It is low at every other time.
- R6: `async_hit`=1 sets the async-detect flag (`flags[2]`).
- R7: While `async_mode`=1 the mismatch flag is never raised, whatever the SDA comparison shows.
- R8: All flags reset to 0 on synchronous active-high `rst`. A set flag stays set until it is cleared.
- R9: A cycle with `wr_en`=1 clears each flag whose `wr_data` bit is 1. Bits written as 0 have no effect, and `wr_data` is ignored when `wr_en`=0.
- R10: If a hardware set and a write-1 clear hit the same flag in one cycle, the flag ends up set.
- R11: `irq` is registered. After each edge it equals `irq_en` from the cycle before the edge ANDed with the OR of the flags after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_sda | input | 1 | Level the slave intends on SDA (1 = released) |
| sda_in | input | 1 | Level sampled on the SDA line |
| sda_stb | input | 1 | SDA sampling strobe |
| tx_active | input | 1 | Slave is driving SDA as transmitter |
| selected | input | 1 | Slave is currently addressed |
| ack_valid | input | 1 | Acknowledge bit after a transmitted byte is valid |
| ack_bit | input | 1 | Acknowledge bit from master (1 = NAK) |
| stop_pulse | input | 1 | Stop condition detected (one cycle) |
| async_mode | input | 1 | Asynchronous address detection mode active |
| async_hit | input | 1 | Address detected in asynchronous mode (one cycle) |
| irq_en | input | 1 | Bus-status interrupt enable |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 4 | Write-1-to-clear mask: [3] mismatch, [2] async, [1] NAK, [0] stop |
| flags | output | 4 | Sticky flags, same bit layout as wr_data |
| irq | output | 1 | Level interrupt |
| bus_release | output | 1 | Release and return-to-idle request to the engine |

## Verification
On every cycle the assertions check that each set condition raises its flag at the next edge. They also check that a flag holds until a clear, that a clear without a competing set takes effect, and that async mode keeps the mismatch flag low. They further check that a stop seen while unselected neither sets the stop flag nor requests release, and that a disabled interrupt stays low. The bench scenarios are needed to show the negative cases across combined stimuli. These include agreement and a missing strobe leaving the mismatch flag clear, a written 0 leaving flags untouched, and the release pulse lasting exactly one cycle. They also show the interrupt dropping only after the last set flag is cleared.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int FLAG_W    = 4;
  localparam int IDX_STOP  = 0;
  localparam int IDX_NAK   = 1;
  localparam int IDX_ASYNC = 2;
  localparam int IDX_MISM  = 3;
endpackage

// File: rtl/bsm_sda_check.sv
module bsm_sda_check (
  input  logic drv_sda,
  input  logic sda_in,
  input  logic sda_stb,
  input  logic tx_active,
  input  logic async_mode,
  output logic mism_set
);
  logic differ;

  always_comb begin
    differ   = drv_sda ^ sda_in;
    mism_set = sda_stb & tx_active & ~async_mode & differ;
  end
endmodule

// File: rtl/bsm_flag.sv
module bsm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic d,
  output logic q
);
  always_comb begin
    if (set)      d = 1'b1;
    else if (clr) d = 1'b0;
    else          d = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q);
endmodule

// File: rtl/i2c_bus_status_mon.sv
module i2c_bus_status_mon
  import bsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              drv_sda,
  input  logic              sda_in,
  input  logic              sda_stb,
  input  logic              tx_active,
  input  logic              selected,
  input  logic              ack_valid,
  input  logic              ack_bit,
  input  logic              stop_pulse,
  input  logic              async_mode,
  input  logic              async_hit,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              bus_release
);
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] flag_d;
  logic              mism_set;
  logic              stop_sel;

  bsm_sda_check u_cmp (
    .drv_sda    (drv_sda),
    .sda_in     (sda_in),
    .sda_stb    (sda_stb),
    .tx_active  (tx_active),
    .async_mode (async_mode),
    .mism_set   (mism_set)
  );

  always_comb begin
    stop_sel            = stop_pulse & selected;
    set_vec             = '0;
    set_vec[IDX_MISM]   = mism_set;
    set_vec[IDX_ASYNC]  = async_hit;
    set_vec[IDX_NAK]    = ack_valid & ack_bit;
    set_vec[IDX_STOP]   = stop_sel;
    clr_vec             = wr_en ? wr_data : '0;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    bsm_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (set_vec[i]),
      .clr (clr_vec[i]),
      .d   (flag_d[i]),
      .q   (flags[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq         <= 1'b0;
      bus_release <= 1'b0;
    end else begin
      irq         <= irq_en & (|flag_d);
      bus_release <= stop_sel;
    end
  end

  // R1
  mism_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_stb && tx_active && !async_mode && (sda_in != drv_sda)) |=> flags[IDX_MISM]);
  // R7
  async_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (async_mode && !flags[IDX_MISM]) |=> !flags[IDX_MISM]);
  // R3
  nak_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_bit) |=> flags[IDX_NAK]);
  // R4
  stop_unsel_chk: assert property (@(posedge clk) disable iff (rst)
    (!selected && !flags[IDX_STOP]) |=> !flags[IDX_STOP]);
  // R5
  release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_pulse && selected) |=> (bus_release && flags[IDX_STOP]));
  // R5
  release_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(stop_pulse && selected) |=> !bus_release);
  // R6
  async_raise_chk: assert property (@(posedge clk) disable iff (rst)
    async_hit |=> flags[IDX_ASYNC]);
  // R11
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
  // R11
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_en && (|flags) && !wr_en) |=> irq);
endmodule

// File: tb/sim_i2c_bus_status_mon.sv
module sim_i2c_bus_status_mon;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       drv_sda, sda_in, sda_stb, tx_active, selected;
  logic       ack_valid, ack_bit, stop_pulse, async_mode, async_hit;
  logic       irq_en, wr_en;
  logic [3:0] wr_data;
  logic [3:0] flags;
  logic       irq, bus_release;

  always #5 clk = ~clk;

  i2c_bus_status_mon u0 (
    .clk(clk), .rst(rst), .drv_sda(drv_sda), .sda_in(sda_in), .sda_stb(sda_stb),
    .tx_active(tx_active), .selected(selected), .ack_valid(ack_valid), .ack_bit(ack_bit),
    .stop_pulse(stop_pulse), .async_mode(async_mode), .async_hit(async_hit),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
    .flags(flags), .irq(irq), .bus_release(bus_release)
  );

  typedef struct {
    logic drv, sda, stb, tx, sel, ackv, ackb, stop, amode, ahit, ien, wen;
    logic [3:0] wd;
  } stim_t;

  typedef struct {
    logic [3:0] f;
    logic       irq;
    logic       rel;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         n_tests = 0;
  int         n_fail  = 0;
  logic [3:0] mdl     = 4'b0;
  bit         done    = 0;

  function automatic stim_t idle();
    stim_t s;
    s.drv = 1'b1; s.sda = 1'b1; s.stb = 1'b0; s.tx = 1'b0; s.sel = 1'b0;
    s.ackv = 1'b0; s.ackb = 1'b0; s.stop = 1'b0; s.amode = 1'b0; s.ahit = 1'b0;
    s.ien = 1'b0; s.wen = 1'b0; s.wd = 4'b0;
    return s;
  endfunction

  task automatic apply(stim_t s);
    drv_sda = s.drv; sda_in = s.sda; sda_stb = s.stb; tx_active = s.tx;
    selected = s.sel; ack_valid = s.ackv; ack_bit = s.ackb; stop_pulse = s.stop;
    async_mode = s.amode; async_hit = s.ahit; irq_en = s.ien; wr_en = s.wen;
    wr_data = s.wd;
  endtask

  // Driver: drives one cycle of stimulus and pushes the expected result.
  task automatic step(stim_t s, string req);
    logic [3:0] setv, clrv;
    exp_t e;
    @(negedge clk);
    apply(s);
    setv[3] = s.stb & s.tx & ~s.amode & (s.drv ^ s.sda);
    setv[2] = s.ahit;
    setv[1] = s.ackv & s.ackb;
    setv[0] = s.stop & s.sel;
    clrv    = s.wen ? s.wd : 4'b0;
    mdl     = (mdl & ~clrv) | setv;
    e.f = mdl; e.irq = s.ien & (|mdl); e.rel = setv[0]; e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each result just after the edge that produced it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (flags !== e.f || irq !== e.irq || bus_release !== e.rel) begin
          n_fail++;
          $display("FAIL %s: flags=%b irq=%b rel=%b expected flags=%b irq=%b rel=%b",
                   e.req, flags, irq, bus_release, e.f, e.irq, e.rel);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    stim_t s;
    apply(idle());
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R8 reset state
    n_tests++;
    if (flags !== 4'b0 || irq !== 1'b0 || bus_release !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: flags=%b irq=%b rel=%b expected 0000 0 0", flags, irq, bus_release);
    end

    // R2: agreement, no strobe, not transmitting
    s = idle(); s.stb = 1; s.tx = 1; s.drv = 0; s.sda = 0; step(s, "R2 agree");
    s = idle(); s.stb = 0; s.tx = 1; s.drv = 1; s.sda = 0; step(s, "R2 no strobe");
    s = idle(); s.stb = 1; s.tx = 0; s.drv = 1; s.sda = 0; step(s, "R2 not tx");
    // R1 mismatch
    s = idle(); s.stb = 1; s.tx = 1; s.drv = 1; s.sda = 0; step(s, "R1 mismatch");
    s = idle(); step(s, "R8 sticky mismatch");
    // R9: write without enable, write 0, then write 1
    s = idle(); s.wd = 4'b1000; step(s, "R9 no wr_en");
    s = idle(); s.wen = 1; s.wd = 4'b0111; step(s, "R9 write zero");
    s = idle(); s.wen = 1; s.wd = 4'b1000; step(s, "R9 clear mismatch");
    // R3 NAK
    s = idle(); s.ackv = 1; s.ackb = 0; step(s, "R3 ack");
    s = idle(); s.ackv = 1; s.ackb = 1; step(s, "R3 nak");
    // R4 / R5 stop
    s = idle(); s.stop = 1; s.sel = 0; step(s, "R4 stop unselected");
    s = idle(); s.stop = 1; s.sel = 1; step(s, "R4 R5 stop selected");
    s = idle(); s.sel = 1; step(s, "R5 release one cycle");
    // R7 async suppression, R6 async hit
    s = idle(); s.amode = 1; s.stb = 1; s.tx = 1; s.drv = 1; s.sda = 0; step(s, "R7 async quiet");
    s = idle(); s.amode = 1; s.ahit = 1; step(s, "R6 async hit");
    // R11 interrupt
    s = idle(); s.ien = 1; step(s, "R11 irq on");
    s = idle(); s.ien = 0; step(s, "R11 irq disabled");
    s = idle(); s.ien = 1; s.wen = 1; s.wd = 4'b0011; step(s, "R11 partial clear");
    s = idle(); s.ien = 1; s.wen = 1; s.wd = 4'b0100; step(s, "R11 all clear");
    s = idle(); s.ien = 1; step(s, "R11 stays low");
    // R10 set wins over clear
    s = idle(); s.ien = 1; s.ackv = 1; s.ackb = 1; s.wen = 1; s.wd = 4'b0010; step(s, "R10 set wins");
    s = idle(); s.ien = 1; s.stb = 1; s.tx = 1; s.drv = 0; s.sda = 1;
    s.wen = 1; s.wd = 4'b1010; step(s, "R10 set wins mismatch");
    s = idle(); s.wen = 1; s.wd = 4'b1111; step(s, "R9 clear all");

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule